// File: doc/BRIEF.md
# Raster Line and Frame Timer

This block produces the horizontal sync, vertical sync and blanking signals for a display whose frame holds 512 visible lines. It also keeps the number of the current line. A line lasts a fixed number of clocks: a prescaler divides the clock into ticks, and a tick counter counts the ticks in each line. With the default values, an 18.432 MHz clock divided by 8 and then by 72 gives a line rate of about 32 kHz.

After the visible lines comes a short vertical region. It contains an offset, then the vertical sync pulse, then a back porch. All three are counted in whole lines after the last visible line. At the end of the back porch the line counter returns to 0 and a new frame starts. Each line also issues two one-clock requests to the memory sequencer, in a fixed order. The first ends the burst of the previous line. The second, one clock later, opens the row whose address is the current line number.

Top module: `raster_timer`

## Requirements
- R1: `line_start` is high for exactly one clock at the start of each line, and lines start every PRESCALE*LINE_TICKS clocks.
- R2: `hsync_n` is low for the first HSYNC_TICKS*PRESCALE clocks of every line and high for the rest of the line.
- R3: On lines 0 to ACTIVE_LINES-1, `blank_n` is low exactly while `hsync_n` is low and high for the rest of the line.
- R4: On lines ACTIVE_LINES and later, `blank_n` stays low for the whole line.
- R5: `vsync_n` is low for every clock of lines ACTIVE_LINES+VS_OFFSET through ACTIVE_LINES+VS_OFFSET+VS_LINES-1, and high on all other lines.
- R6: `line` goes up by one at each line start. After line ACTIVE_LINES+VS_OFFSET+VS_LINES+BACK_PORCH-1 it returns to 0. It changes at no other time.
- R7: `row_open` is high for exactly one clock, the clock right after `line_start`. The `line` value it comes with is the row to open.
- R8: While `rst_n` is low, `line` is 0, `hsync_n` is 0, `blank_n` is 0, `vsync_n` is 1, `line_start` is 1 and `row_open` is 0. The first clock after reset is released begins line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | Low while the picture is blanked |
| line | output | LINE_W | Current line number; also the row address to open |
| line_start | output | 1 | One-clock request to end the previous burst |
| row_open | output | 1 | One-clock request to open row `line` |

## Verification
Two things can happen in the same clock. The frame wrap, where the line counter returns to 0 and blanking is released, can land on a line start that also begins a sync pulse. The edges of the vertical sync also land on line starts. The bench uses a small configuration and follows it clock by clock across three whole frames, so every line-start clock is covered, including the wrap clock and both vertical sync edges. For each clock it works out the expected line number and position within the line from the count of clocks since reset. It then checks all six outputs against that expected state.

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int PRESCALE     = 8,
  parameter int LINE_TICKS   = 72,
  parameter int HSYNC_TICKS  = 2,
  parameter int ACTIVE_LINES = 512,
  parameter int VS_OFFSET    = 0,
  parameter int VS_LINES     = 5,
  parameter int BACK_PORCH   = 15,
  parameter int LINE_W       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              blank_n,
  output logic [LINE_W-1:0] line,
  output logic              line_start,
  output logic              row_open
);
  localparam int FRAME_LINES = ACTIVE_LINES + VS_OFFSET + VS_LINES + BACK_PORCH;
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int TW = (LINE_TICKS > 1) ? $clog2(LINE_TICKS) : 1;

  localparam logic [PW-1:0]     PC_LAST  = PW'(PRESCALE - 1);
  localparam logic [TW-1:0]     TC_LAST  = TW'(LINE_TICKS - 1);
  localparam logic [TW-1:0]     HS_TICKS = TW'(HSYNC_TICKS);
  localparam logic [LINE_W-1:0] LN_LAST  = LINE_W'(FRAME_LINES - 1);
  localparam logic [LINE_W-1:0] LN_ACT   = LINE_W'(ACTIVE_LINES);
  localparam logic [LINE_W-1:0] VS_FIRST = LINE_W'(ACTIVE_LINES + VS_OFFSET);
  localparam logic [LINE_W-1:0] VS_LAST  = LINE_W'(ACTIVE_LINES + VS_OFFSET + VS_LINES - 1);

  logic [PW-1:0] pc;
  logic [TW-1:0] tc;
  logic pc_end, tc_end;

  assign pc_end = (pc == PC_LAST);
  assign tc_end = (tc == TC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      tc   <= '0;
      line <= '0;
    end else if (pc_end) begin
      pc <= '0;
      if (tc_end) begin
        tc   <= '0;
        line <= (line == LN_LAST) ? '0 : line + 1'b1;
      end else begin
        tc <= tc + 1'b1;
      end
    end else begin
      pc <= pc + 1'b1;
    end
  end

  assign line_start = (tc == '0) && (pc == '0);
  assign row_open   = (tc == '0) && (pc == PW'(1));
  assign hsync_n    = (tc >= HS_TICKS);
  assign blank_n    = hsync_n && (line < LN_ACT);
  assign vsync_n    = !((line >= VS_FIRST) && (line <= VS_LAST));

  initial begin
    p_cfg_fits_r6: assert (FRAME_LINES <= (1 << LINE_W) && PRESCALE >= 2 && VS_LINES >= 1);
  end

  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);
  p_open_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> row_open);
  p_open_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    row_open |-> $past(line_start));
  p_hs_blanks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> !blank_n);
  p_vs_blanked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !blank_n);
  p_line_moves_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line) |-> line_start);
  p_wrap_from_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(line) && line == '0) |-> $past(line) == LN_LAST);
endmodule

// File: tb/raster_timer_test.sv
module raster_timer_test;
  localparam int P  = 2;
  localparam int LT = 6;
  localparam int HS = 2;
  localparam int AL = 8;
  localparam int VO = 1;
  localparam int VL = 2;
  localparam int BP = 3;
  localparam int LW = 4;
  localparam int FL = AL + VO + VL + BP;
  localparam int CPL = P * LT;

  logic clk = 0;
  logic rst_n = 0;
  logic hsync_n, vsync_n, blank_n, line_start, row_open;
  logic [LW-1:0] line;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  raster_timer #(.PRESCALE(P), .LINE_TICKS(LT), .HSYNC_TICKS(HS), .ACTIVE_LINES(AL),
                 .VS_OFFSET(VO), .VS_LINES(VL), .BACK_PORCH(BP), .LINE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n), .blank_n(blank_n),
    .line(line), .line_start(line_start), .row_open(row_open));

  task automatic check(input string req, input int got, input int exp, input int cyc);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: got %0d expected %0d", req, cyc, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 line", int'(line), 0, -1);
    check("R8 hsync_n", int'(hsync_n), 0, -1);
    check("R8 blank_n", int'(blank_n), 0, -1);
    check("R8 vsync_n", int'(vsync_n), 1, -1);
    check("R8 line_start", int'(line_start), 1, -1);
    check("R8 row_open", int'(row_open), 0, -1);
    rst_n = 1;
    for (int n = 0; n < 3 * FL * CPL + 5; n++) begin
      int ln, pos, e_hs, e_bl, e_vs;
      ln   = (n / CPL) % FL;
      pos  = n % CPL;
      e_hs = (pos < HS * P) ? 0 : 1;
      e_bl = (ln < AL) ? e_hs : 0;
      e_vs = (ln >= AL + VO && ln < AL + VO + VL) ? 0 : 1;
      check("R6 line", int'(line), ln, n);
      check("R2 hsync_n", int'(hsync_n), e_hs, n);
      if (ln < AL) check("R3 blank_n", int'(blank_n), e_bl, n);
      else         check("R4 blank_n", int'(blank_n), e_bl, n);
      check("R5 vsync_n", int'(vsync_n), e_vs, n);
      check("R1 line_start", int'(line_start), (pos == 0) ? 1 : 0, n);
      check("R7 row_open", int'(row_open), (pos == 1) ? 1 : 0, n);
      @(posedge clk);
      @(negedge clk);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule